// File: doc/BRIEF.md
# Bus Trace Capture with Idle Drop

This block watches the request and response traffic of one bus master socket, picked from several by a select input. It stores one compact record per finished transaction in a small circular trace memory. A request is taken when the slave accepts it, and it is held in a short in-order queue. When the matching response arrives, the command, address, data and response code are written together as one aligned record. The record also carries a free-running 16-bit timestamp. Cycles with no command, cycles that wait for the slave, and cycles that wait for a response take no trace memory. The timestamp still lets a host work out how long each gap was. If the counter wraps while nothing is being written, the block writes a marker record so that the wrap is not lost.

Capture is started by a host arm pulse or by a cross-trigger start input. Once armed, the block waits for a stop condition. That condition is either a masked address and command match on an accepted request, or a cross-trigger stop input. After it, the block keeps recording for a programmed number of further records and then halts. When capture is halted, a debug host reads the trace memory through a read address input and a registered data output. Outputs also give the write pointer and a flag that says the buffer has wrapped.

Top module: `bus_trace_capture`

## Requirements
- R1: After reset the block is stopped (`busy`=0, `triggered`=0), `wr_ptr` is 0, `wrapped` is 0 and `rd_data` is 0. The timestamp counter starts at 0 on the first clock after reset and advances by one on every clock.
- R2: While stopped, a high `host_arm` or `xtrig_start` on a clock edge starts capture (`busy`=1 from the next cycle) and clears `wr_ptr` and `wrapped`. These inputs have no effect while capture runs.
- R3: On the selected socket, a request with a non-zero command and `accept` high is queued. Up to 4 requests can wait. Each response (`rvalid` high) is paired in order with the oldest queued request. A response that arrives with nothing queued is dropped and writes nothing.
- R4: While capture runs, a record is written on the clock edge of each paired response. Its layout, from MSB to LSB, is {timestamp[15:0], socket index[1:0], command[2:0], address[15:0], data[15:0], response[1:0]}. The data field is the request write data when the command is 1 (write), and the response read data for any other command.
- R5: Cycles without an accepted request or a paired response write nothing, and `wr_ptr` does not move. Each write advances `wr_ptr` by one, modulo 16. Nothing is written while stopped.
- R6: The timestamp field holds the counter value at the clock edge on which the record is written.
- R7: While capture runs, on an edge where the counter equals 16'hFFFF and no response record is written, a marker record is written. It has timestamp 16'hFFFF, command 0, and zero address, data and response.
- R8: While armed and not yet triggered, a trigger occurs on an accepted request whose command equals `match_cmd` and whose address equals `match_addr` in every bit where `match_mask` is 1. A high `xtrig_stop` also causes a trigger.
- R9: After a trigger, `triggered` is 1 and capture goes on until `post_count` further records (markers included) have been written, then stops. With `post_count` 0, capture stops on the edge after the trigger.
- R10: `wrapped` goes to 1 when a record is written into the last entry (index 15), and it stays at 1 until the next start.
- R11: While stopped, `rd_data` shows the entry at `rd_addr` one cycle later. While capture runs, `rd_data` holds its value.
- R12: Only the socket chosen by `src_sel` is traced. Traffic on the other sockets has no effect, and the socket index field of each record equals `src_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sock_cmd | input | NSOCK*3 | Request command per socket, 0 = none, 1 = write |
| sock_addr | input | NSOCK*AW | Request address per socket |
| sock_wdata | input | NSOCK*DW | Request write data per socket |
| sock_accept | input | NSOCK | Slave accepts the request this cycle |
| sock_rvalid | input | NSOCK | Response valid this cycle |
| sock_resp | input | NSOCK*2 | Response code per socket |
| sock_rdata | input | NSOCK*DW | Response read data per socket |
| src_sel | input | SW | Index of the traced socket |
| host_arm | input | 1 | Host start request |
| xtrig_start | input | 1 | Cross-trigger start |
| xtrig_stop | input | 1 | Cross-trigger stop event |
| match_addr | input | AW | Trigger address value |
| match_mask | input | AW | Trigger address compare mask, 1 = compare |
| match_cmd | input | 3 | Trigger command value |
| post_count | input | CW | Records kept after the trigger |
| rd_addr | input | PW | Host read index |
| rd_data | output | RW | Registered record at the read index |
| wr_ptr | output | PW | Next trace entry to be written |
| wrapped | output | 1 | The buffer has wrapped since the last start |
| busy | output | 1 | Capture is running |
| triggered | output | 1 | Trigger seen, post-trigger phase running |

## Verification
The hardest case to reach is the timestamp wrap marker. It needs capture to stay armed through a full 65536-cycle period of the counter with no response landing on the wrap edge. The stimulus arms capture with a trigger command that never occurs, leaves the bus idle until the counter nears its top, and then stops through the cross-trigger input so that the marker can be read back. A second hard case is the post-trigger count. The trigger comes from an accepted request, but the records that follow come from later responses. The bench therefore interleaves matching requests with responses and sends one extra transaction after the stop point, to show that it is not recorded.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_STOP = 2'd0,
    ST_ARM  = 2'd1,
    ST_POST = 2'd2
  } cap_state_e;

  localparam logic [2:0] CMD_IDLE  = 3'd0;
  localparam logic [2:0] CMD_WRITE = 3'd1;
  localparam int         TS_W      = 16;
endpackage

// File: rtl/trc_pend_fifo.sv
module trc_pend_fifo #(
  parameter int W     = 35,
  parameter int DEPTH = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  logic [W-1:0] mem_q [DEPTH];
  logic [IW-1:0] rp_q, rp_d, wp_q, wp_d;
  logic [IW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (IW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem_q[rp_q];

  always_comb begin
    rp_d  = rp_q;
    wp_d  = wp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = wp_q + 1'b1;
    if (do_pop)  rp_d = rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      rp_q  <= rp_d;
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= pdata;
  end

  // R3: the master never has more than DEPTH requests waiting
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && full && !pop));
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (IW+1)'(DEPTH));
endmodule

// File: rtl/trc_trigger.sv
module trc_trigger
  import trc_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          req_fire,
  input  logic [2:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] match_addr,
  input  logic [AW-1:0] match_mask,
  input  logic [2:0]    match_cmd,
  input  logic          xtrig_stop,
  input  logic          wr_any,
  input  logic [CW-1:0] post_count,
  output cap_state_e    st,
  output logic          clear
);
  cap_state_e    st_q, st_d;
  logic [CW-1:0] pc_q, pc_d;
  logic          local_hit, hit;

  assign local_hit = req_fire && (((req_addr ^ match_addr) & match_mask) == '0)
                     && (req_cmd == match_cmd);
  assign hit = xtrig_stop || local_hit;
  assign st  = st_q;

  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    clear = 1'b0;
    case (st_q)
      ST_STOP: if (start_req) begin
        st_d  = ST_ARM;
        clear = 1'b1;
      end
      ST_ARM: if (hit) begin
        pc_d = '0;
        st_d = (post_count == '0) ? ST_STOP : ST_POST;
      end
      ST_POST: if (wr_any) begin
        if ({1'b0, pc_q} + 1'b1 == {1'b0, post_count}) st_d = ST_STOP;
        else pc_d = pc_q + 1'b1;
      end
      default: st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_STOP;
      pc_q <= '0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
    end
  end

  // R9: the post-trigger phase is only entered from the armed phase
  p_post_from_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_POST) |-> $past(st_q) == ST_ARM);
  // R2: a start only takes effect from the stopped state
  p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && start_req) |=> st_q == ST_ARM);
endmodule

// File: rtl/trc_ram.sv
module trc_ram #(
  parameter int RW    = 55,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          we,
  input  logic [RW-1:0] wdata,
  input  logic          rd_en,
  input  logic [PW-1:0] rd_addr,
  output logic [RW-1:0] rd_data,
  output logic [PW-1:0] wr_ptr,
  output logic          wrapped
);
  logic [RW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_d;
  logic          wrap_q, wrap_d;
  logic [RW-1:0] rd_q, rd_d;

  assign wr_ptr  = ptr_q;
  assign wrapped = wrap_q;
  assign rd_data = rd_q;

  always_comb begin
    ptr_d  = ptr_q;
    wrap_d = wrap_q;
    rd_d   = rd_en ? mem_q[rd_addr] : rd_q;
    if (clear) begin
      ptr_d  = '0;
      wrap_d = 1'b0;
    end else if (we) begin
      ptr_d = ptr_q + 1'b1;
      if (ptr_q == PW'(DEPTH - 1)) wrap_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
      rd_q   <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      ptr_q  <= ptr_d;
      wrap_q <= wrap_d;
      rd_q   <= rd_d;
      if (we) mem_q[ptr_q] <= wdata;
    end
  end

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clear) |=> wr_ptr == $past(wr_ptr) + 1'b1);
  p_wrap_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !clear) |=> wrapped);
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && clear));
endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture
  import trc_pkg::*;
#(
  parameter int NSOCK = 4,
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  parameter int PEND  = 4,
  parameter int CW    = 8,
  localparam int SW   = $clog2(NSOCK),
  localparam int PW   = $clog2(DEPTH),
  localparam int RW   = TS_W + SW + 3 + AW + DW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSOCK*3-1:0] sock_cmd,
  input  logic [NSOCK*AW-1:0] sock_addr,
  input  logic [NSOCK*DW-1:0] sock_wdata,
  input  logic [NSOCK-1:0]   sock_accept,
  input  logic [NSOCK-1:0]   sock_rvalid,
  input  logic [NSOCK*2-1:0] sock_resp,
  input  logic [NSOCK*DW-1:0] sock_rdata,
  input  logic [SW-1:0]      src_sel,
  input  logic               host_arm,
  input  logic               xtrig_start,
  input  logic               xtrig_stop,
  input  logic [AW-1:0]      match_addr,
  input  logic [AW-1:0]      match_mask,
  input  logic [2:0]         match_cmd,
  input  logic [CW-1:0]      post_count,
  input  logic [PW-1:0]      rd_addr,
  output logic [RW-1:0]      rd_data,
  output logic [PW-1:0]      wr_ptr,
  output logic               wrapped,
  output logic               busy,
  output logic               triggered
);
  localparam int QW = 3 + AW + DW;

  logic [2:0]    cmd_a   [NSOCK];
  logic [AW-1:0] addr_a  [NSOCK];
  logic [DW-1:0] wd_a    [NSOCK];
  logic [DW-1:0] rd_a    [NSOCK];
  logic [1:0]    resp_a  [NSOCK];

  for (genvar g = 0; g < NSOCK; g++) begin : g_unpack
    assign cmd_a[g]  = sock_cmd[g*3 +: 3];
    assign addr_a[g] = sock_addr[g*AW +: AW];
    assign wd_a[g]   = sock_wdata[g*DW +: DW];
    assign rd_a[g]   = sock_rdata[g*DW +: DW];
    assign resp_a[g] = sock_resp[g*2 +: 2];
  end

  logic [2:0]    s_cmd;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata, s_rdata;
  logic [1:0]    s_resp;
  logic          s_accept, s_rvalid;

  assign s_cmd    = cmd_a[src_sel];
  assign s_addr   = addr_a[src_sel];
  assign s_wdata  = wd_a[src_sel];
  assign s_rdata  = rd_a[src_sel];
  assign s_resp   = resp_a[src_sel];
  assign s_accept = sock_accept[src_sel];
  assign s_rvalid = sock_rvalid[src_sel];

  // timestamp
  logic [TS_W-1:0] ts_q, ts_d;
  assign ts_d = ts_q + 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_d;
  end

  // pending request queue
  logic          req_fire;
  logic [QW-1:0] q_head;
  logic          q_empty, q_full;

  assign req_fire = (s_cmd != CMD_IDLE) && s_accept;

  trc_pend_fifo #(.W(QW), .DEPTH(PEND)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_fire),
    .pdata ({s_cmd, s_addr, s_wdata}),
    .pop   (s_rvalid),
    .head  (q_head),
    .empty (q_empty),
    .full  (q_full)
  );

  // capture control
  cap_state_e st;
  logic       clear, ram_we, rec_we, mark_we, capturing;

  assign capturing = (st != ST_STOP);
  assign rec_we    = capturing && s_rvalid && !q_empty;
  assign mark_we   = capturing && (ts_q == '1) && !rec_we;
  assign ram_we    = rec_we || mark_we;

  trc_trigger #(.AW(AW), .CW(CW)) u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (host_arm || xtrig_start),
    .req_fire   (req_fire),
    .req_cmd    (s_cmd),
    .req_addr   (s_addr),
    .match_addr (match_addr),
    .match_mask (match_mask),
    .match_cmd  (match_cmd),
    .xtrig_stop (xtrig_stop),
    .wr_any     (ram_we),
    .post_count (post_count),
    .st         (st),
    .clear      (clear)
  );

  // record assembly
  logic [2:0]    h_cmd;
  logic [AW-1:0] h_addr;
  logic [DW-1:0] h_wdata, rec_dat;
  logic [RW-1:0] rec;

  assign {h_cmd, h_addr, h_wdata} = q_head;
  assign rec_dat = (h_cmd == CMD_WRITE) ? h_wdata : s_rdata;

  always_comb begin
    if (rec_we) rec = {ts_q, src_sel, h_cmd, h_addr, rec_dat, s_resp};
    else        rec = {ts_q, src_sel, CMD_IDLE, {AW{1'b0}}, {DW{1'b0}}, 2'b00};
  end

  trc_ram #(.RW(RW), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .we      (ram_we),
    .wdata   (rec),
    .rd_en   (st == ST_STOP),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_ptr  (wr_ptr),
    .wrapped (wrapped)
  );

  assign busy      = capturing;
  assign triggered = (st == ST_POST);

  p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ts_q == $past(ts_q) + 1'b1);
  p_idle_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_rvalid && ts_q != '1) |-> !ram_we);
  p_stop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(wr_ptr) || $past(host_arm || xtrig_start));
endmodule

// File: tb/sim_bus_trace_capture.sv
module sim_bus_trace_capture;
  localparam int NS = 4;

  logic clk, rst_n;
  logic [2:0]  b_cmd [NS];
  logic [15:0] b_addr [NS], b_wd [NS], b_rd [NS];
  logic        b_acc [NS], b_rv [NS];
  logic [1:0]  b_rs [NS];

  logic [NS*3-1:0]  sock_cmd;
  logic [NS*16-1:0] sock_addr, sock_wdata, sock_rdata;
  logic [NS-1:0]    sock_accept, sock_rvalid;
  logic [NS*2-1:0]  sock_resp;
  logic [1:0]  src_sel;
  logic        host_arm, xtrig_start, xtrig_stop;
  logic [15:0] match_addr, match_mask;
  logic [2:0]  match_cmd;
  logic [7:0]  post_count;
  logic [3:0]  rd_addr;
  logic [54:0] rd_data;
  logic [3:0]  wr_ptr;
  logic        wrapped, busy, triggered;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      sock_cmd[i*3 +: 3]     = b_cmd[i];
      sock_addr[i*16 +: 16]  = b_addr[i];
      sock_wdata[i*16 +: 16] = b_wd[i];
      sock_rdata[i*16 +: 16] = b_rd[i];
      sock_accept[i]         = b_acc[i];
      sock_rvalid[i]         = b_rv[i];
      sock_resp[i*2 +: 2]    = b_rs[i];
    end
  end

  bus_trace_capture u0 (
    .clk(clk), .rst_n(rst_n), .sock_cmd(sock_cmd), .sock_addr(sock_addr),
    .sock_wdata(sock_wdata), .sock_accept(sock_accept), .sock_rvalid(sock_rvalid),
    .sock_resp(sock_resp), .sock_rdata(sock_rdata), .src_sel(src_sel),
    .host_arm(host_arm), .xtrig_start(xtrig_start), .xtrig_stop(xtrig_stop),
    .match_addr(match_addr), .match_mask(match_mask), .match_cmd(match_cmd),
    .post_count(post_count), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_ptr(wr_ptr), .wrapped(wrapped), .busy(busy), .triggered(triggered)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit running = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int          m_st, m_pc, m_wp;
  bit          m_wrap;
  logic [15:0] m_ts;
  logic [54:0] m_ram [16];
  logic [54:0] m_rd;
  logic [34:0] m_q [$];

  always @(posedge clk or negedge rst_n) begin
    logic [2:0] c; logic [15:0] a; logic acc, rv, fire, rec, mark, we, hit, full0;
    logic [34:0] h; logic [54:0] wd; int os;
    if (!rst_n) begin
      m_st = 0; m_pc = 0; m_wp = 0; m_wrap = 0; m_ts = 0; m_rd = '0;
      m_q.delete();
      for (int i = 0; i < 16; i++) m_ram[i] = '0;
    end else begin
      c = b_cmd[src_sel]; a = b_addr[src_sel];
      acc = b_acc[src_sel]; rv = b_rv[src_sel];
      fire = (c != 0) && acc;
      full0 = (m_q.size() == 4);
      rec = 0; wd = '0;
      if (rv && m_q.size() > 0) begin
        h = m_q.pop_front();
        rec = (m_st != 0);
        wd = {m_ts, src_sel, h[34:32], h[31:16],
              (h[34:32] == 3'd1) ? h[15:0] : b_rd[src_sel], b_rs[src_sel]};
      end
      if (fire && !full0) m_q.push_back({c, a, b_wd[src_sel]});
      mark = (m_st != 0) && (m_ts == 16'hFFFF) && !rec;
      if (mark) wd = {m_ts, src_sel, 3'd0, 16'd0, 16'd0, 2'd0};
      we = rec || mark;
      hit = xtrig_stop || (fire && (((a ^ match_addr) & match_mask) == 0) && c == match_cmd);
      if (m_st == 0) m_rd = m_ram[rd_addr];
      if (we) begin
        m_ram[m_wp] = wd;
        if (m_wp == 15) m_wrap = 1;
        m_wp = (m_wp + 1) % 16;
      end
      os = m_st;
      case (os)
        0: if (host_arm || xtrig_start) begin m_st = 1; m_wp = 0; m_wrap = 0; end
        1: if (hit) begin m_pc = 0; m_st = (post_count == 0) ? 0 : 2; end
        default: if (we) begin
          if (m_pc + 1 == int'(post_count)) m_st = 0; else m_pc++;
        end
      endcase
      m_ts = m_ts + 1'b1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      chk("R2 busy", 64'(busy), 64'(m_st != 0));
      chk("R9 triggered", 64'(triggered), 64'(m_st == 2));
      chk("R5 wr_ptr", 64'(wr_ptr), 64'(m_wp));
      chk("R10 wrapped", 64'(wrapped), 64'(m_wrap));
      chk("R11 rd_data", 64'(rd_data), 64'(m_rd));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic req(int s, logic [2:0] c, logic [15:0] a, logic [15:0] w, int nw);
    b_cmd[s] = c; b_addr[s] = a; b_wd[s] = w; b_acc[s] = 0;
    repeat (nw) @(negedge clk);
    b_acc[s] = 1;
    @(negedge clk);
    b_cmd[s] = 0; b_acc[s] = 0;
  endtask

  task automatic rsp(int s, logic [1:0] r, logic [15:0] d, int nw, output logic [15:0] tsv);
    repeat (nw) @(negedge clk);
    b_rv[s] = 1; b_rs[s] = r; b_rd[s] = d;
    tsv = m_ts;
    @(negedge clk);
    b_rv[s] = 0;
  endtask

  task automatic pulse_stop();
    post_count = 0; xtrig_stop = 1;
    @(negedge clk);
    xtrig_stop = 0;
    @(negedge clk);
  endtask

  task automatic readk(int k);
    rd_addr = 4'(k);
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    logic [15:0] t0, t1, tx;
    rst_n = 0; src_sel = 1; host_arm = 0; xtrig_start = 0; xtrig_stop = 0;
    match_addr = 0; match_mask = 0; match_cmd = 3'd7; post_count = 2; rd_addr = 0;
    for (int i = 0; i < NS; i++) begin
      b_cmd[i] = 0; b_addr[i] = 0; b_wd[i] = 0; b_rd[i] = 0;
      b_acc[i] = 0; b_rv[i] = 0; b_rs[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 wr_ptr", 64'(wr_ptr), 0);
    chk("R1 wrapped", 64'(wrapped), 0);
    chk("R1 rd_data", 64'(rd_data), 0);
    running = 1;

    // R2 arm from host; R12 noise on socket 2
    host_arm = 1; @(negedge clk); host_arm = 0;
    b_cmd[2] = 3'd2; b_acc[2] = 1; b_rv[2] = 1; b_rd[2] = 16'h7777;
    req(1, 3'd1, 16'h1234, 16'hA5A5, 2);
    req(1, 3'd2, 16'h0040, 16'h0000, 0);
    rsp(1, 2'd0, 16'h1111, 3, t0);
    rsp(1, 2'd1, 16'hBEEF, 1, t1);
    rsp(1, 2'd2, 16'h2222, 2, tx);   // R3 nothing pending: dropped
    b_cmd[2] = 0; b_acc[2] = 0; b_rv[2] = 0;
    repeat (3) @(negedge clk);
    chk("R3 R5 two records only", 64'(wr_ptr), 2);
    pulse_stop();
    readk(0);
    chk("R4 write record addr", 64'(rd_data[33:18]), 64'h1234);
    chk("R4 write record data", 64'(rd_data[17:2]), 64'hA5A5);
    chk("R4 write record cmd", 64'(rd_data[36:34]), 1);
    chk("R6 timestamp rec0", 64'(rd_data[54:39]), 64'(t0));
    chk("R12 socket field", 64'(rd_data[38:37]), 1);
    readk(1);
    chk("R4 read record data", 64'(rd_data[17:2]), 64'hBEEF);
    chk("R4 read record resp", 64'(rd_data[1:0]), 1);
    chk("R6 timestamp rec1", 64'(rd_data[54:39]), 64'(t1));

    // R2 re-arm by cross-trigger; R3 four pending
    xtrig_start = 1; @(negedge clk); xtrig_start = 0;
    chk("R2 cleared ptr", 64'(wr_ptr), 0);
    for (int i = 0; i < 4; i++) req(1, 3'd2, 16'(16'h0100 + i), 16'h0, 0);
    for (int i = 0; i < 4; i++) rsp(1, 2'd0, 16'(16'hC000 + i), 0, tx);
    @(negedge clk);
    chk("R3 four paired", 64'(wr_ptr), 4);
    // R10 wrap the buffer
    for (int i = 0; i < 14; i++) begin
      req(1, 3'd1, 16'(16'h0200 + i), 16'(16'hD000 + i), i % 3);
      rsp(1, 2'(i), 16'h0, i % 2, tx);
    end
    @(negedge clk);
    chk("R10 wrapped", 64'(wrapped), 1);

    // R8 masked trigger, R9 three post records
    match_addr = 16'h03FF; match_mask = 16'hFF00; match_cmd = 3'd2; post_count = 3;
    req(1, 3'd2, 16'h0211, 16'h0, 0);   // address mismatch
    rsp(1, 2'd0, 16'h0, 0, tx);
    chk("R8 no trigger on mismatch", 64'(triggered), 0);
    req(1, 3'd2, 16'h03AB, 16'h0, 1);
    @(negedge clk);
    chk("R8 trigger on match", 64'(triggered), 1);
    rsp(1, 2'd0, 16'hE000, 0, tx);
    for (int i = 0; i < 2; i++) begin
      req(1, 3'd2, 16'(16'h0400 + i), 16'h0, 0);
      rsp(1, 2'd0, 16'(16'hE001 + i), 0, tx);
    end
    @(negedge clk);
    chk("R9 stopped after post count", 64'(busy), 0);
    req(1, 3'd1, 16'h0500, 16'h5555, 0);
    rsp(1, 2'd0, 16'h0, 0, tx);
    for (int k = 0; k < 16; k++) begin
      readk(k);
      chk("R11 readback", 64'(rd_data), 64'(m_ram[k]));
    end

    // R7 marker across timestamp wrap
    match_cmd = 3'd7; post_count = 5;
    host_arm = 1; @(negedge clk); host_arm = 0;
    while (m_ts != 16'hFFF0) @(negedge clk);
    repeat (20) @(negedge clk);
    pulse_stop();
    chk("R7 one marker", 64'(wr_ptr), 1);
    readk(0);
    chk("R7 marker ts", 64'(rd_data[54:39]), 64'hFFFF);
    chk("R7 marker cmd", 64'(rd_data[36:34]), 0);
    chk("R7 marker addr", 64'(rd_data[33:18]), 0);

    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule